// File: doc/BRIEF.md
# Endian-Configurable Unaligned Load Unit

This block forms the register-write value for loads in a 32-bit RISC core. It receives the byte address of the access, the access width, the load kind and the aligned memory word that holds the addressed byte. From these it produces the value to write into the destination register, a per-byte write-enable mask and a misalignment flag. The previous content of the destination register is an input. Bytes outside the mask keep that old value, so partial loads can be merged into the register.

Byte order is captured from a strap input while reset is asserted and is then held until the next reset. Normal loads of a byte, half-word or word pick the correct byte lanes for the captured order and sign- or zero-extend narrow values. Two partial kinds, "upper" and "lower", each move part of a word into one end of the register. Run one after the other, they rebuild a word that starts at any address. Everything except the order flop is combinational.

Top module: `load_align_unit`

## Requirements
- R1: The byte order is captured from `bigEndianIn` only while `rstN` is low (1 = big endian, 0 = little endian). Changing `bigEndianIn` after reset has no effect on any output.
- R2: Memory lane convention: in little endian the byte at word offset k is on `memWordIn[8k+7:8k]`, and in big endian it is on lane 3-k. A normal word load (`sizeIn`=2 or 3, `kindIn`=0 or 3) at offset 0 returns `memWordIn` unchanged, with mask 4'b1111.
- R3: A normal byte load (`sizeIn`=0) returns the byte at the addressed offset, sign-extended when `signedIn`=1 and zero-extended otherwise, at any offset.
- R4: A normal half-word load (`sizeIn`=1) at an even offset o returns the two bytes at o and o+1, extended per `signedIn`. The byte at o is most significant in big endian and least significant in little endian.
- R5: A normal half-word load at an odd offset, or a normal word load at a non-zero offset, sets `alignFaultOut`, drives mask 4'b0000 and returns `oldRegIn` unchanged.
- R6: Big endian upper load (`kindIn`=1) at offset o places the bytes at offsets o..3 into register bytes 3 down to 3-(3-o), so offset o lands in byte 3. Register bytes below that keep their old values.
- R7: Big endian lower load (`kindIn`=2) at offset o places the bytes at offsets 0..o into register bytes o down to 0, so offset o lands in byte 0. Offset 3 loads the full word, and offset 0 writes only bits 7:0.
- R8: In little endian the lane choice is mirrored. The upper load at offset o places offsets 0..o into the top o+1 register bytes, with offset o in byte 3. The lower load at offset o places offsets o..3 into the low bytes, with offset o in byte 0.
- R9: Upper and lower loads never set `alignFaultOut`, for any address or size.
- R10: `resultOut` equals `(oldRegIn & ~M) | (aligned & M)`, where M expands `byteEnOut` per byte. A successful normal load has `byteEnOut` = 4'b1111.
- R11: A word at unaligned address A is rebuilt in big endian by an upper load at A followed by a lower load at A+3, and in little endian by a lower load at A followed by an upper load at A+3. Each step feeds the previous result back as `oldRegIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the byte-order flop |
| rstN | input | 1 | Active-low asynchronous reset; byte order is captured while low |
| bigEndianIn | input | 1 | Byte-order strap, 1 = big endian |
| addrIn | input | ADDR_W | Byte address of the access |
| sizeIn | input | 2 | 0 byte, 1 half-word, 2 or 3 word |
| kindIn | input | 2 | 0 or 3 normal, 1 upper partial, 2 lower partial |
| signedIn | input | 1 | Sign-extend narrow normal loads |
| memWordIn | input | 32 | Aligned memory word containing the addressed byte |
| oldRegIn | input | 32 | Current destination register value |
| resultOut | output | 32 | Merged register write value |
| byteEnOut | output | 4 | Register byte write-enable mask |
| alignFaultOut | output | 1 | Misaligned normal load |

## Verification
The case that is hardest to reach is a change of `bigEndianIn` during operation. No normal stimulus ever moves the strap after reset, so the bench toggles it on purpose and checks that byte loads still follow the captured order. The two-step unaligned rebuild is also hard to reach by chance: the second load must read the next word, with the first result fed back as the old register value. Directed sequences cover it in both orders. Random stimulus from a fixed seed runs under a second reset into the opposite byte order, so the mirrored lane selection is exercised as well.

// File: rtl/load_align_pkg.sv
package load_align_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BYTES  = DATA_W / 8;
  localparam int unsigned OFF_W  = $clog2(BYTES);

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_WIDE = 2'd3} size_e;
  typedef enum logic [1:0] {LK_NORMAL = 2'd0, LK_UPPER = 2'd1, LK_LOWER = 2'd2, LK_RSVD = 2'd3} kind_e;
  typedef enum logic [2:0] {PICK_BYTE, PICK_HALF, PICK_WORD, PICK_UPPER, PICK_LOWER} pick_e;

  typedef struct packed {
    pick_e            pick;
    logic [OFF_W-1:0] lane;
    logic             signExt;
    logic             fault;
    logic [BYTES-1:0] mask;
  } ldu_strobe_t;
endpackage

// File: rtl/load_align_ctrl.sv
module load_align_ctrl
  import load_align_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             bigEndianIn,
  input  logic [OFF_W-1:0] offsetIn,
  input  size_e            sizeIn,
  input  kind_e            kindIn,
  input  logic             signedIn,
  output ldu_strobe_t      strobes
);
  localparam logic [OFF_W-1:0] LAST    = OFF_W'(BYTES - 1);
  localparam logic [BYTES-1:0] ALL_ONE = '1;

  logic bigEndReg;
  logic [OFF_W-1:0] effOff;

  // byte order follows the strap only while reset is held
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bigEndReg <= bigEndianIn;
  end

  assign effOff = bigEndReg ? offsetIn : (LAST - offsetIn);

  always_comb begin
    strobes         = '0;
    strobes.pick    = PICK_WORD;
    strobes.signExt = signedIn;
    strobes.mask    = ALL_ONE;
    unique case (kindIn)
      LK_UPPER: begin
        strobes.pick = PICK_UPPER;
        strobes.lane = effOff;
        strobes.mask = ALL_ONE << effOff;
      end
      LK_LOWER: begin
        strobes.pick = PICK_LOWER;
        strobes.lane = LAST - effOff;
        strobes.mask = ALL_ONE >> (LAST - effOff);
      end
      default: begin
        unique case (sizeIn)
          SZ_BYTE: begin
            strobes.pick = PICK_BYTE;
            strobes.lane = bigEndReg ? (LAST - offsetIn) : offsetIn;
          end
          SZ_HALF: begin
            strobes.pick  = PICK_HALF;
            strobes.fault = offsetIn[0];
            strobes.lane  = bigEndReg ? (LAST - OFF_W'(1) - offsetIn) : offsetIn;
          end
          default: begin
            strobes.pick  = PICK_WORD;
            strobes.fault = (offsetIn != '0);
          end
        endcase
        if (strobes.fault) strobes.mask = '0;
      end
    endcase
  end

  // R9
  property partial_no_fault_p;
    @(posedge clk) disable iff (!rstN)
      (kindIn == LK_UPPER || kindIn == LK_LOWER) |-> !strobes.fault;
  endproperty
  partial_no_fault_chk: assert property (partial_no_fault_p);

  // R6
  upper_fills_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (kindIn == LK_UPPER) |-> strobes.mask[BYTES-1]);

  // R7
  lower_fills_bottom_chk: assert property (@(posedge clk) disable iff (!rstN)
    (kindIn == LK_LOWER) |-> strobes.mask[0]);

  // R5
  fault_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fault |-> (strobes.mask == '0));
endmodule

// File: rtl/load_align_dp.sv
module load_align_dp
  import load_align_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ldu_strobe_t       strobes,
  input  logic [DATA_W-1:0] memWordIn,
  input  logic [DATA_W-1:0] oldRegIn,
  output logic [DATA_W-1:0] resultOut,
  output logic [BYTES-1:0]  byteEnOut
);
  logic [DATA_W-1:0] downShift;
  logic [DATA_W-1:0] upShift;
  logic [DATA_W-1:0] aligned;
  logic [DATA_W-1:0] bitMask;
  logic [7:0]        byteVal;
  logic [15:0]       halfVal;

  assign downShift = memWordIn >> {strobes.lane, 3'b000};
  assign upShift   = memWordIn << {strobes.lane, 3'b000};
  assign byteVal   = downShift[7:0];
  assign halfVal   = downShift[15:0];

  always_comb begin
    unique case (strobes.pick)
      PICK_BYTE:  aligned = {{(DATA_W-8){strobes.signExt & byteVal[7]}}, byteVal};
      PICK_HALF:  aligned = {{(DATA_W-16){strobes.signExt & halfVal[15]}}, halfVal};
      PICK_UPPER: aligned = upShift;
      PICK_LOWER: aligned = downShift;
      default:    aligned = memWordIn;
    endcase
  end

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign bitMask[8*i +: 8] = {8{strobes.mask[i]}};
  end

  assign resultOut = (oldRegIn & ~bitMask) | (aligned & bitMask);
  assign byteEnOut = strobes.mask;

  // R10
  keep_unmasked_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((resultOut ^ oldRegIn) & ~bitMask) == '0);

  // R5
  fault_keeps_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fault |-> (resultOut == oldRegIn));
endmodule

// File: rtl/load_align_unit.sv
module load_align_unit
  import load_align_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bigEndianIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [1:0]        sizeIn,
  input  logic [1:0]        kindIn,
  input  logic              signedIn,
  input  logic [31:0]       memWordIn,
  input  logic [31:0]       oldRegIn,
  output logic [31:0]       resultOut,
  output logic [3:0]        byteEnOut,
  output logic              alignFaultOut
);
  ldu_strobe_t strobes;
  logic        unusedAddrBits;

  assign unusedAddrBits = ^addrIn[ADDR_W-1:OFF_W];

  load_align_ctrl ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bigEndianIn(bigEndianIn),
    .offsetIn   (addrIn[OFF_W-1:0]),
    .sizeIn     (size_e'(sizeIn)),
    .kindIn     (kind_e'(kindIn)),
    .signedIn   (signedIn),
    .strobes    (strobes)
  );

  load_align_dp dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .memWordIn(memWordIn),
    .oldRegIn (oldRegIn),
    .resultOut(resultOut),
    .byteEnOut(byteEnOut)
  );

  assign alignFaultOut = strobes.fault;

  // R10
  normal_full_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((kindIn == 2'd0 || kindIn == 2'd3) && !alignFaultOut) |-> (byteEnOut == 4'hF));
endmodule

// File: tb/load_align_unit_test.sv
module load_align_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bigEndianIn = 1'b1;
  logic [31:0] addrIn = '0;
  logic [1:0]  sizeIn = '0;
  logic [1:0]  kindIn = '0;
  logic        signedIn = 1'b0;
  logic [31:0] memWordIn = '0;
  logic [31:0] oldRegIn = '0;
  logic [31:0] resultOut;
  logic [3:0]  byteEnOut;
  logic        alignFaultOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  load_align_unit uut (
    .clk(clk), .rstN(rstN), .bigEndianIn(bigEndianIn), .addrIn(addrIn),
    .sizeIn(sizeIn), .kindIn(kindIn), .signedIn(signedIn), .memWordIn(memWordIn),
    .oldRegIn(oldRegIn), .resultOut(resultOut), .byteEnOut(byteEnOut),
    .alignFaultOut(alignFaultOut)
  );

  // expected {fault, mask, result} from the byte-level requirements
  function automatic logic [36:0] model(bit big, logic [1:0] o, logic [1:0] sz,
                                        logic [1:0] kd, bit sgn, logic [31:0] mem,
                                        logic [31:0] old);
    logic [7:0]  mb [4];
    logic [7:0]  rb [4];
    logic [3:0]  m;
    logic [31:0] v;
    logic        f;
    int oi;
    oi = int'(o);
    for (int k = 0; k < 4; k++) mb[k] = big ? mem[8*(3-k) +: 8] : mem[8*k +: 8];
    for (int j = 0; j < 4; j++) rb[j] = old[8*j +: 8];
    f = 1'b0; m = 4'h0;
    if (kd == 2'd1) begin
      if (big) for (int k = oi; k < 4; k++) begin rb[3-(k-oi)] = mb[k]; m[3-(k-oi)] = 1'b1; end
      else     for (int k = 0; k <= oi; k++) begin rb[3-oi+k] = mb[k]; m[3-oi+k] = 1'b1; end
    end else if (kd == 2'd2) begin
      if (big) for (int k = 0; k <= oi; k++) begin rb[oi-k] = mb[k]; m[oi-k] = 1'b1; end
      else     for (int k = oi; k < 4; k++) begin rb[k-oi] = mb[k]; m[k-oi] = 1'b1; end
    end else begin
      if (sz == 2'd0) v = {{24{sgn & mb[oi][7]}}, mb[oi]};
      else if (sz == 2'd1) begin
        if (o[0]) f = 1'b1;
        else if (big) v = {{16{sgn & mb[oi][7]}}, mb[oi], mb[oi+1]};
        else          v = {{16{sgn & mb[oi+1][7]}}, mb[oi+1], mb[oi]};
      end else begin
        if (o != 2'd0) f = 1'b1;
        else v = big ? {mb[0], mb[1], mb[2], mb[3]} : {mb[3], mb[2], mb[1], mb[0]};
      end
      if (!f) begin
        m = 4'hF;
        for (int j = 0; j < 4; j++) rb[j] = v[8*j +: 8];
      end
    end
    return {f, m, rb[3], rb[2], rb[1], rb[0]};
  endfunction

  function automatic string reqOf(bit big, logic [1:0] o, logic [1:0] sz, logic [1:0] kd);
    if (kd == 2'd1 || kd == 2'd2) return big ? ((kd == 2'd1) ? "R6" : "R7") : "R8";
    if (sz == 2'd0) return "R3";
    if (sz == 2'd1) return o[0] ? "R5" : "R4";
    return (o != 2'd0) ? "R5" : "R2";
  endfunction

  task automatic apply(bit big, logic [31:0] a, logic [1:0] sz, logic [1:0] kd, bit sgn,
                       logic [31:0] mem, logic [31:0] old, string req);
    logic [36:0] exp;
    @(negedge clk);
    addrIn = a; sizeIn = sz; kindIn = kd; signedIn = sgn; memWordIn = mem; oldRegIn = old;
    #1;
    exp = model(big, a[1:0], sz, kd, sgn, mem, old);
    checks++;
    if ({alignFaultOut, byteEnOut, resultOut} !== exp) begin
      errors++;
      $display("FAIL %s addr=%h: got fault=%b en=%b res=%h, expected fault=%b en=%b res=%h",
               req, a, alignFaultOut, byteEnOut, resultOut, exp[36], exp[35:32], exp[31:0]);
    end
  endtask

  task automatic expectWord(logic [31:0] want, string req);
    checks++;
    if (resultOut !== want) begin
      errors++;
      $display("FAIL %s rebuild: got %h expected %h", req, resultOut, want);
    end
  endtask

  task automatic doReset(bit big);
    @(negedge clk);
    rstN = 1'b0; bigEndianIn = big;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic randomRun(bit big, int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] a;
      logic [1:0]  sz, kd;
      a  = $urandom; sz = 2'($urandom); kd = 2'($urandom);
      apply(big, a, sz, kd, 1'($urandom), $urandom, $urandom, reqOf(big, a[1:0], sz, kd));
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    doReset(1'b1);
    // R1 / R2 after reset: big endian word
    apply(1, 32'h400000, 2'd2, 2'd0, 0, 32'h56789ABC, 32'h0, "R1");
    apply(1, 32'h10, 2'd3, 2'd3, 0, 32'hDEADBEEF, 32'h1, "R2");
    // R3 sign and zero, every offset
    for (int o = 0; o < 4; o++) begin
      apply(1, 32'(o), 2'd0, 2'd0, 1, 32'h80FF7F01, 32'h5, "R3");
      apply(1, 32'(o), 2'd0, 2'd0, 0, 32'h80FF7F01, 32'h5, "R3");
    end
    // R4
    apply(1, 32'h2, 2'd1, 2'd0, 1, 32'h1234F00D, 32'h0, "R4");
    apply(1, 32'h0, 2'd1, 2'd0, 0, 32'hF00D1234, 32'h0, "R4");
    // R5 misaligned
    apply(1, 32'h1, 2'd1, 2'd0, 0, 32'h11223344, 32'hCAFEBABE, "R5");
    apply(1, 32'h2, 2'd2, 2'd0, 0, 32'h11223344, 32'hCAFEBABE, "R5");
    apply(1, 32'h3, 2'd2, 2'd0, 1, 32'h11223344, 32'h0BADF00D, "R5");
    // R6 / R7 / R9 at all offsets
    for (int o = 0; o < 4; o++) begin
      apply(1, 32'(o), 2'd2, 2'd1, 0, 32'h89ABCDEF, 32'h01234567, "R6");
      apply(1, 32'(o), 2'd1, 2'd2, 0, 32'h89ABCDEF, 32'h01234567, "R7");
    end
    // R11 big endian rebuild of 0x56789abc at base+1
    apply(1, 32'h1001, 2'd2, 2'd1, 0, 32'hAA56789A, 32'h0, "R11");
    apply(1, 32'h1004, 2'd2, 2'd2, 0, 32'hBC112233, resultOut, "R11");
    expectWord(32'h56789ABC, "R11");
    // R1 strap change while running has no effect
    @(negedge clk); bigEndianIn = 1'b0;
    repeat (3) @(negedge clk);
    apply(1, 32'h0, 2'd0, 2'd0, 0, 32'hA1B2C3D4, 32'h0, "R1");
    apply(1, 32'h1, 2'd1, 2'd1, 0, 32'hA1B2C3D4, 32'h0, "R1");
    randomRun(1, 400);

    doReset(1'b0);
    apply(0, 32'h400000, 2'd2, 2'd0, 0, 32'h56789ABC, 32'h0, "R1");
    apply(0, 32'h1, 2'd0, 2'd0, 1, 32'h0000F000, 32'h0, "R3");
    apply(0, 32'h2, 2'd1, 2'd0, 1, 32'h80010000, 32'h0, "R4");
    for (int o = 0; o < 4; o++) begin
      apply(0, 32'(o), 2'd0, 2'd1, 0, 32'h89ABCDEF, 32'h01234567, "R8");
      apply(0, 32'(o), 2'd3, 2'd2, 0, 32'h89ABCDEF, 32'h01234567, "R8");
    end
    // R11 little endian rebuild
    apply(0, 32'h2001, 2'd2, 2'd2, 0, 32'h789ABCAA, 32'h0, "R11");
    apply(0, 32'h2004, 2'd2, 2'd1, 0, 32'h33221156, resultOut, "R11");
    expectWord(32'h56789ABC, "R11");
    @(negedge clk); bigEndianIn = 1'b1;
    apply(0, 32'h3, 2'd0, 2'd0, 0, 32'hA1B2C3D4, 32'h0, "R1");
    randomRun(0, 400);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule